// File: doc/BRIEF.md
# Half-Page Read Address Stepper

This block turns a byte-range read request against a small-page NAND array into an ordered series of segment descriptors. Each descriptor is one read operation for the downstream read engine. The array is handled in 256-byte chunks, which match the ECC granule. A request gives a start byte address, a byte length and a page-size mode (256-byte or 512-byte pages). The block checks the range against the device size in the cycle that accepts the request. It then issues one descriptor per valid/ready handshake until the requested length has been delivered.

Each descriptor carries four fields: which read pointer to use (first half or second half of the page), a column inside the 256-byte half, a page number and a byte count. The first descriptor starts at the column derived from the start address. Every later descriptor starts at column 0. In 512-byte mode the half selection alternates from one segment to the next, and the page advances only after a second-half segment. In 256-byte mode every segment uses the first-half pointer and the page advances after every segment. The last descriptor of a request is flagged.

Top module: `hp_read_stepper`

## Requirements
- R1: While reset is high and in the first cycle after it, seg_valid is 0, req_reject is 0 and req_ready is 1.
- R2: In 256-byte mode (req_page512=0), the first segment has page = addr>>8, column = addr[7:0] and half = 0 (first-half pointer).
- R3: In 512-byte mode (req_page512=1), the first segment has page = addr>>9, half = addr[8] (0 first-half pointer, 1 second-half pointer) and column = addr[7:0], which is the raw in-page column minus 256 when it is 256 or more.
- R4: Each segment's byte count is the smaller of (256 - column) and the bytes still outstanding. seg_last is 1 exactly on the segment that delivers the final byte. No segment follows it.
- R5: Every segment after the first of a request has column 0.
- R6: After each accepted segment, the page increments if the mode is 256-byte or the segment used the second-half pointer. The half toggles after every segment in 512-byte mode and stays 0 in 256-byte mode.
- R7: A request with length 0, or with addr + len greater than 2^DEV_LOG2, is rejected. req_reject is 1 for the single cycle after acceptance, and no segment is issued.
- R8: A segment is consumed only on seg_valid and seg_ready both high. While seg_valid is high and seg_ready is low, every descriptor field holds. req_ready is low while segments of a request are pending.
- R9: For an accepted in-range request, the first segment is valid in the cycle right after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | DEV_LOG2 | Start byte address |
| req_len | input | DEV_LOG2+1 | Length in bytes |
| req_page512 | input | 1 | 1 selects 512-byte pages, 0 selects 256-byte pages |
| req_reject | output | 1 | One-cycle pulse for a rejected request |
| seg_valid | output | 1 | Segment descriptor offered |
| seg_ready | input | 1 | Read engine takes the descriptor |
| seg_half | output | 1 | 0 first-half read pointer, 1 second-half read pointer |
| seg_col | output | 8 | Column inside the 256-byte half |
| seg_page | output | DEV_LOG2-8 | Page number |
| seg_count | output | 9 | Bytes in this segment, 1 to 256 |
| seg_last | output | 1 | Final segment of the request |

## Verification
On every cycle, the assertions check the following:
- descriptors hold while stalled;
- byte counts lie between 1 and the room left in the half;
- later segments restart at column 0;
- the half bit stays 0 in 256-byte mode and alternates in 512-byte mode;
- the page steps only as the mode allows;
- nothing follows a last segment or accompanies a reject.

Only the bench's scenarios can show that the start page, column and half match the request address, that the counts add up to exactly the requested length, and that range rejection sits at the exact device-size boundary. The bench sweeps addresses and lengths in both modes against an arithmetic model, with the ready signal throttled.

// File: rtl/hps_pkg.sv
package hps_pkg;
    localparam int HALF_BYTES = 256;
    localparam int COL_W      = 8;
    localparam int CNT_W      = 9;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    // room left in a 256-byte half from a given column, 1..256
    function automatic logic [CNT_W-1:0] half_room(input logic [COL_W-1:0] col);
        return {1'b0, ~col} + CNT_W'(1);
    endfunction
endpackage

// File: rtl/hps_start_decode.sv
module hps_start_decode
    import hps_pkg::*;
#(
    parameter int DEV_LOG2 = 12,
    parameter int ADDR_W   = DEV_LOG2,
    parameter int LEN_W    = DEV_LOG2 + 1,
    parameter int PAGE_W   = DEV_LOG2 - 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic              page512,
    output logic [PAGE_W-1:0] page,
    output logic [COL_W-1:0]  col,
    output half_e             half,
    output logic              reject
);
    localparam int SUM_W = DEV_LOG2 + 2;
    localparam logic [SUM_W-1:0] LIMIT = SUM_W'(1) << DEV_LOG2;

    logic [SUM_W-1:0] end_addr;

    always_comb begin
        end_addr = SUM_W'(addr) + SUM_W'(len);
        reject   = (len == '0) || (end_addr > LIMIT);
        col      = addr[COL_W-1:0];
        if (page512) begin
            page = {1'b0, addr[ADDR_W-1:9]};
            half = addr[8] ? HALF_HI : HALF_LO;
        end else begin
            page = addr[ADDR_W-1:8];
            half = HALF_LO;
        end
    end
endmodule

// File: rtl/hps_seg_size.sv
module hps_seg_size
    import hps_pkg::*;
#(
    parameter int LEN_W = 13
) (
    input  logic [COL_W-1:0] col,
    input  logic [LEN_W-1:0] remaining,
    output logic [CNT_W-1:0] count,
    output logic             last
);
    logic [LEN_W-1:0] room;

    always_comb begin
        room  = LEN_W'(half_room(col));
        last  = (remaining <= room);
        count = last ? remaining[CNT_W-1:0] : room[CNT_W-1:0];
    end
endmodule

// File: rtl/hps_cursor.sv
module hps_cursor
    import hps_pkg::*;
#(
    parameter int LEN_W  = 13,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PAGE_W-1:0] ld_page,
    input  logic [COL_W-1:0]  ld_col,
    input  half_e             ld_half,
    input  logic [LEN_W-1:0]  ld_len,
    input  logic              ld_page512,
    input  logic              step,
    input  logic [CNT_W-1:0]  step_count,
    input  logic              step_last,
    output logic              busy,
    output logic              page512,
    output logic [PAGE_W-1:0] page,
    output logic [COL_W-1:0]  col,
    output half_e             half,
    output logic [LEN_W-1:0]  remaining
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            page512   <= 1'b0;
            page      <= '0;
            col       <= '0;
            half      <= HALF_LO;
            remaining <= '0;
        end else if (load) begin
            busy      <= 1'b1;
            page512   <= ld_page512;
            page      <= ld_page;
            col       <= ld_col;
            half      <= ld_half;
            remaining <= ld_len;
        end else if (step) begin
            remaining <= remaining - LEN_W'(step_count);
            col       <= '0;
            if (!page512 || half == HALF_HI)
                page <= page + PAGE_W'(1);
            if (page512)
                half <= (half == HALF_HI) ? HALF_LO : HALF_HI;
            if (step_last)
                busy <= 1'b0;
        end
    end
endmodule

// File: rtl/hp_read_stepper.sv
module hp_read_stepper
    import hps_pkg::*;
#(
    parameter int DEV_LOG2 = 12,
    parameter int ADDR_W   = DEV_LOG2,
    parameter int LEN_W    = DEV_LOG2 + 1,
    parameter int PAGE_W   = DEV_LOG2 - 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_page512,
    output logic              req_reject,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic              seg_half,
    output logic [COL_W-1:0]  seg_col,
    output logic [PAGE_W-1:0] seg_page,
    output logic [CNT_W-1:0]  seg_count,
    output logic              seg_last
);
    logic [PAGE_W-1:0] d_page;
    logic [COL_W-1:0]  d_col;
    half_e             d_half;
    logic              d_reject;

    logic              busy_q;
    logic              p512_q;
    half_e             half_q;
    logic [LEN_W-1:0]  rem_q;
    logic              accept;
    logic              take;
    logic              reject_q;

    hps_start_decode #(
        .DEV_LOG2(DEV_LOG2), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W)
    ) u_decode (
        .addr    (req_addr),
        .len     (req_len),
        .page512 (req_page512),
        .page    (d_page),
        .col     (d_col),
        .half    (d_half),
        .reject  (d_reject)
    );

    assign req_ready = !busy_q;
    assign accept    = req_valid && req_ready;
    assign seg_valid = busy_q;
    assign take      = seg_valid && seg_ready;

    hps_cursor #(.LEN_W(LEN_W), .PAGE_W(PAGE_W)) u_cursor (
        .clk        (clk),
        .rst        (rst),
        .load       (accept && !d_reject),
        .ld_page    (d_page),
        .ld_col     (d_col),
        .ld_half    (d_half),
        .ld_len     (req_len),
        .ld_page512 (req_page512),
        .step       (take),
        .step_count (seg_count),
        .step_last  (seg_last),
        .busy       (busy_q),
        .page512    (p512_q),
        .page       (seg_page),
        .col        (seg_col),
        .half       (half_q),
        .remaining  (rem_q)
    );

    hps_seg_size #(.LEN_W(LEN_W)) u_size (
        .col       (seg_col),
        .remaining (rem_q),
        .count     (seg_count),
        .last      (seg_last)
    );

    assign seg_half = (half_q == HALF_HI);

    always_ff @(posedge clk) begin
        if (rst) reject_q <= 1'b0;
        else     reject_q <= accept && d_reject;
    end
    assign req_reject = reject_q;
endmodule

// File: rtl/hps_checker.sv
module hps_checker #(
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              seg_valid,
    input logic              seg_ready,
    input logic              seg_half,
    input logic [7:0]        seg_col,
    input logic [PAGE_W-1:0] seg_page,
    input logic [8:0]        seg_count,
    input logic              seg_last,
    input logic              req_reject,
    input logic              mode512
);
    // R8: descriptor held while stalled
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_page) && $stable(seg_col)
            && $stable(seg_half) && $stable(seg_count) && $stable(seg_last));

    // R4: count within the half's room and nonzero
    a_r4_count_range: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> (seg_count != 9'd0) && ({1'b0, seg_col} + seg_count <= 10'd256));

    // R4: nothing follows the last segment
    a_r4_end_after_last: assert property (@(posedge clk) disable iff (rst)
        seg_valid && seg_ready && seg_last |=> !seg_valid);

    // R5: later segments restart at column 0
    a_r5_col_zero: assert property (@(posedge clk) disable iff (rst)
        seg_valid && seg_ready && !seg_last |=> seg_valid && seg_col == 8'd0);

    // R6: half stays first in 256-byte mode
    a_r6_half_256: assert property (@(posedge clk) disable iff (rst)
        seg_valid && !mode512 |-> !seg_half);

    // R6: half alternates in 512-byte mode
    a_r6_half_toggle: assert property (@(posedge clk) disable iff (rst)
        seg_valid && seg_ready && !seg_last && mode512 |=> seg_half != $past(seg_half));

    // R6: page step rule
    a_r6_page_step: assert property (@(posedge clk) disable iff (rst)
        seg_valid && seg_ready && !seg_last |=>
            seg_page == $past(seg_page) + ((!$past(mode512) || $past(seg_half)) ? PAGE_W'(1) : PAGE_W'(0)));

    // R7: a reject comes with no segment
    a_r7_reject_quiet: assert property (@(posedge clk) disable iff (rst)
        req_reject |-> !seg_valid);
endmodule

bind hp_read_stepper hps_checker #(.PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .seg_valid  (seg_valid),
    .seg_ready  (seg_ready),
    .seg_half   (seg_half),
    .seg_col    (seg_col),
    .seg_page   (seg_page),
    .seg_count  (seg_count),
    .seg_last   (seg_last),
    .req_reject (req_reject),
    .mode512    (p512_q)
);

// File: tb/hp_read_stepper_tb.sv
module hp_read_stepper_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEV_LOG2   = 12;
    localparam int DEV_SIZE   = 1 << DEV_LOG2;
    localparam int PAGE_W     = DEV_LOG2 - 8;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [DEV_LOG2-1:0] req_addr = '0;
    logic [DEV_LOG2:0]   req_len = '0;
    logic req_page512 = 1'b0;
    logic req_reject;
    logic seg_valid;
    logic seg_ready = 1'b0;
    logic seg_half;
    logic [7:0] seg_col;
    logic [PAGE_W-1:0] seg_page;
    logic [8:0] seg_count;
    logic seg_last;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [7:0] lfsr = 8'hA5;

    always #(CLK_PERIOD/2) clk = ~clk;

    hp_read_stepper #(.DEV_LOG2(DEV_LOG2)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_page512(req_page512),
        .req_reject(req_reject), .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_half(seg_half), .seg_col(seg_col), .seg_page(seg_page),
        .seg_count(seg_count), .seg_last(seg_last)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung act=%0d exp=<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic run_req(input int a, input int l, input bit m);
        int page, col, half, rem, cnt, nseg;
        bit last, done, rdy, rej;
        rej = (l == 0) || (a + l > DEV_SIZE);
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 req_ready idle", int'(req_ready), 1);
        req_valid = 1'b1; req_addr = a[DEV_LOG2-1:0]; req_len = l[DEV_LOG2:0]; req_page512 = m;
        @(negedge clk);
        req_valid = 1'b0;
        if (rej) begin
            chk(req_reject == 1'b1, "R7 reject pulse", int'(req_reject), 1);
            chk(seg_valid == 1'b0, "R7 no segment", int'(seg_valid), 0);
            @(negedge clk);
            chk(req_reject == 1'b0 && seg_valid == 1'b0, "R7 reject single cycle",
                int'({req_reject, seg_valid}), 0);
            return;
        end
        chk(seg_valid == 1'b1 && req_reject == 1'b0, "R9 first segment next cycle",
            int'({seg_valid, req_reject}), 2);
        chk(req_ready == 1'b0, "R8 busy blocks request", int'(req_ready), 0);
        rem = l;
        col = a % 256;
        if (m) begin page = a / 512; half = (a / 256) % 2; end
        else   begin page = a / 256; half = 0; end
        nseg = 0;
        done = 0;
        while (!done) begin
            cnt  = (rem < 256 - col) ? rem : 256 - col;
            last = (rem == cnt);
            chk(seg_valid == 1'b1, "R8 segment pending", int'(seg_valid), 1);
            if (nseg == 0) begin
                chk(int'(seg_page) == page, m ? "R3 start page" : "R2 start page", int'(seg_page), page);
                chk(int'(seg_col) == col, m ? "R3 start column" : "R2 start column", int'(seg_col), col);
                chk(int'(seg_half) == half, m ? "R3 start half" : "R2 start half", int'(seg_half), half);
            end else begin
                chk(int'(seg_col) == 0, "R5 later column", int'(seg_col), 0);
                chk(int'(seg_page) == page, "R6 page step", int'(seg_page), page);
                chk(int'(seg_half) == half, "R6 half step", int'(seg_half), half);
            end
            chk(int'(seg_count) == cnt, "R4 count", int'(seg_count), cnt);
            chk(seg_last == last, "R4 last flag", int'(seg_last), int'(last));
            rdy = lfsr[0] | lfsr[3];
            seg_ready = rdy;
            @(negedge clk);
            seg_ready = 1'b0;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (rdy) begin
                nseg = nseg + 1;
                rem = rem - cnt;
                if (!m || half == 1) page = (page + 1) % (1 << PAGE_W);
                if (m) half = 1 - half;
                col = 0;
                if (last) done = 1;
            end
        end
        chk(seg_valid == 1'b0 && req_ready == 1'b1, "R4 no extra segment",
            int'({seg_valid, req_ready}), 1);
    endtask

    initial begin
        int addrs[12];
        int lens[9];
        addrs = '{0, 1, 255, 256, 257, 300, 511, 512, 3840, 3968, 4000, 4095};
        lens  = '{0, 1, 2, 255, 256, 257, 512, 700, 1000};
        repeat (3) @(negedge clk);
        chk(seg_valid == 1'b0 && req_reject == 1'b0 && req_ready == 1'b1, "R1 in reset",
            int'({seg_valid, req_reject, req_ready}), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(seg_valid == 1'b0 && req_reject == 1'b0 && req_ready == 1'b1, "R1 after reset",
            int'({seg_valid, req_reject, req_ready}), 1);
        for (int m = 0; m < 2; m++) begin
            foreach (addrs[i])
                foreach (lens[j])
                    run_req(addrs[i], lens[j], m[0]);
            for (int a = 0; a < DEV_SIZE; a += 61)
                run_req(a, (a * 7) % 900 + 1, m[0]);
            run_req(DEV_SIZE - 600, 600, m[0]);
            run_req(DEV_SIZE - 600, 601, m[0]);
            run_req(0, DEV_SIZE, m[0]);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule